// File: doc/BRIEF.md
# Relative Load-Immediate Instruction Assembler

This block sits after instruction fetch and takes a stream of aligned 16-bit instruction parcels. It accepts one parcel per valid cycle. For each parcel that begins an instruction, it works out the length of the instruction and captures the parcel's address. The short form carries an 8-bit immediate inside the head parcel. The long forms are followed by one, two or four little-endian immediate parcels, which the block collects before it issues anything.

When an instruction completes, the block sign-extends its immediate and adds it to the address of the following instruction. That address is the head address plus the full instruction length. The sum is cut to the register width `XLEN`, which may be 16, 32 or 64. The block then presents one register write, made of index and value, together with the byte length of the instruction. Any other parcel is reported as a 2-byte instruction that makes no write.

`busy` is high while trailing parcels are still outstanding, so that later stages can hold off. The block has no backpressure of its own, and `in_rdy` is always high.

Top module: `rli_assembler`

## Requirements
- R1: During and right after reset, `done`, `wr_en` and `busy` are low and `in_rdy` is high.
- R2: A head parcel whose bits [15:12] are 1110 is the short form. One cycle after it is accepted, `done` and `wr_en` pulse, `len_bytes`=2 and `wr_idx`=bits [7:4]. `wr_data` = address + 2 + the sign-extended byte {bits[11:8], bits[3:0]}.
- R3: A head parcel that is neither the short form nor a long form gives `done` with `len_bytes`=2 one cycle after acceptance, and `wr_en` stays low.
- R4: A long form has bits [15:11]=10101 and bits [3:0]=0000. Its sub-code in bits [10:8] sets the number of trailing parcels: 101 means 1, 110 means 2 and 111 means 4. The register index is in bits [7:4].
- R5: A head with bits [15:11]=10101 but a sub-code below 101, or with nonzero bits [3:0], is handled as in R3.
- R6: Trailing parcels are little-endian: the first one carries immediate bits [15:0] and each later one the next 16 bits. The assembled 16-, 32- or 64-bit immediate is sign-extended from its top bit.
- R7: A long form completes one cycle after its last trailing parcel is accepted. It reports `len_bytes` of 4, 6 or 10, and `wr_data` = head address + `len_bytes` + the sign-extended immediate.
- R8: `wr_data` is the sum cut to its low `XLEN` bits.
- R9: `busy` is high from the cycle after a long-form head is accepted until the cycle in which its `done` appears. Cycles with `in_vld` low leave the collection state unchanged.
- R10: There is exactly one `done` per instruction, `done` never coincides with `busy`, and `wr_en` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Parcel valid |
| in_rdy | output | 1 | Parcel accepted (always high) |
| in_parcel | input | 16 | Instruction parcel |
| in_addr | input | XLEN | Byte address of the parcel; sampled with a head parcel |
| busy | output | 1 | Trailing parcels outstanding |
| done | output | 1 | One-cycle pulse: an instruction completed |
| len_bytes | output | 4 | Byte length of the completed instruction |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register index to write |
| wr_data | output | XLEN | Value to write |

## Verification
The collection state is visible at the ports through `busy` and through when `done` appears. A miscounted trailing-parcel total or slot index shows up at once: `done` arrives early or late, `len_bytes` is wrong, or the immediate lands in the wrong bytes of `wr_data`. The bench compares every output on every clock, so such a fault is caught within one cycle of the first affected instruction. A wrong sign-extension width or a wrong truncation appears only in `wr_data`. For this reason a 16-bit instance runs alongside the 64-bit one, with negative immediates and addresses near the wrap point.

// File: rtl/rli_assembler.sv
module rli_assembler #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  output logic            in_rdy,
  input  logic [15:0]     in_parcel,
  input  logic [XLEN-1:0] in_addr,
  output logic            busy,
  output logic            done,
  output logic [3:0]      len_bytes,
  output logic            wr_en,
  output logic [3:0]      wr_idx,
  output logic [XLEN-1:0] wr_data
);

  localparam int IMM_MAX = 64;

  typedef enum logic {S_HEAD, S_TAIL} state_t;

  state_t             st;
  logic [2:0]         tail_n, tail_k;
  logic [IMM_MAX-1:0] imm_q, imm_all, imm_ext;
  logic [XLEN-1:0]    base_q;
  logic [3:0]         idx_q;

  assign in_rdy = 1'b1;
  assign busy   = (st == S_TAIL);

  wire       take     = in_vld & in_rdy;
  wire       is_short = in_parcel[15:12] == 4'hE;
  wire       is_long  = (in_parcel[15:11] == 5'd21) && in_parcel[10] &&
                        (in_parcel[9:8] != 2'b00) && (in_parcel[3:0] == 4'h0);
  wire [2:0] head_n   = (in_parcel[9:8] == 2'b01) ? 3'd1 :
                        (in_parcel[9:8] == 2'b10) ? 3'd2 : 3'd4;
  wire       last     = (tail_k + 3'd1) == tail_n;
  wire [3:0] len_long = {tail_n, 1'b0} + 4'd2;

  wire [7:0]      imm8   = {in_parcel[11:8], in_parcel[3:0]};
  wire [XLEN-1:0] short_v = {{(XLEN-8){imm8[7]}}, imm8} + in_addr + XLEN'(2);

  always_comb begin
    imm_all = imm_q;
    case (tail_k)
      3'd0:    imm_all[15:0]  = in_parcel;
      3'd1:    imm_all[31:16] = in_parcel;
      3'd2:    imm_all[47:32] = in_parcel;
      default: imm_all[63:48] = in_parcel;
    endcase
    case (tail_n)
      3'd1:    imm_ext = {{48{imm_all[15]}}, imm_all[15:0]};
      3'd2:    imm_ext = {{32{imm_all[31]}}, imm_all[31:0]};
      default: imm_ext = imm_all;
    endcase
  end

  wire [XLEN-1:0] long_v = imm_ext[XLEN-1:0] + base_q + XLEN'(len_long);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HEAD;
      tail_n    <= 3'd1;
      tail_k    <= 3'd0;
      imm_q     <= '0;
      base_q    <= '0;
      idx_q     <= '0;
      done      <= 1'b0;
      wr_en     <= 1'b0;
      len_bytes <= 4'd0;
      wr_idx    <= 4'd0;
      wr_data   <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (take) begin
        if (st == S_HEAD) begin
          if (is_long) begin
            st     <= S_TAIL;
            tail_n <= head_n;
            tail_k <= 3'd0;
            imm_q  <= '0;
            base_q <= in_addr;
            idx_q  <= in_parcel[7:4];
          end else begin
            done      <= 1'b1;
            len_bytes <= 4'd2;
            if (is_short) begin
              wr_en   <= 1'b1;
              wr_idx  <= in_parcel[7:4];
              wr_data <= short_v;
            end
          end
        end else begin
          imm_q  <= imm_all;
          tail_k <= tail_k + 3'd1;
          if (last) begin
            st        <= S_HEAD;
            done      <= 1'b1;
            wr_en     <= 1'b1;
            len_bytes <= len_long;
            wr_idx    <= idx_q;
            wr_data   <= long_v;
          end
        end
      end
    end
  end

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  we_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_vld) |=> busy);

  // R2
  short_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !busy && in_parcel[15:12] == 4'hE) |=> (done && wr_en && len_bytes == 4'd2));

  // R7
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_bytes == 4'd2 || len_bytes == 4'd4 || len_bytes == 4'd6 || len_bytes == 4'd10));

  // R9
  busy_after_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !busy && in_parcel[15:11] == 5'd21 && in_parcel[10] &&
     in_parcel[9:8] != 2'b00 && in_parcel[3:0] == 4'h0) |=> (busy && !done));

endmodule

// File: tb/rli_assembler_test.sv
module rli_assembler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] in_parcel = 16'h0;
  logic [63:0] in_addr = 64'h0;

  logic        rdy_a, busy_a, done_a, we_a;
  logic [3:0]  len_a, idx_a;
  logic [63:0] data_a;
  logic        rdy_b, busy_b, done_b, we_b;
  logic [3:0]  len_b, idx_b;
  logic [15:0] data_b;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rli_assembler #(.XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(rdy_a),
    .in_parcel(in_parcel), .in_addr(in_addr), .busy(busy_a), .done(done_a),
    .len_bytes(len_a), .wr_en(we_a), .wr_idx(idx_a), .wr_data(data_a));

  rli_assembler #(.XLEN(16)) uut_w16 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(rdy_b),
    .in_parcel(in_parcel), .in_addr(in_addr[15:0]), .busy(busy_b), .done(done_b),
    .len_bytes(len_b), .wr_en(we_b), .wr_idx(idx_b), .wr_data(data_b));

  // behavioural reference
  int          need = 0, got = 0, total = 0;
  logic [63:0] m_imm = 0, m_base = 0;
  logic [3:0]  m_idx = 0;
  logic        e_done = 0, e_we = 0;
  logic [3:0]  e_len = 0, e_idx = 0;
  logic [63:0] e_data = 0;
  string       e_tag = "R1";

  always @(posedge clk) begin
    e_done = 0; e_we = 0;
    if (!rst_n) begin
      need = 0; e_tag = "R1";
    end else if (in_vld) begin
      if (need == 0) begin
        if (in_parcel[15:12] == 4'hE) begin
          logic [63:0] s8;
          s8 = {{56{in_parcel[11]}}, in_parcel[11:8], in_parcel[3:0]};
          e_done = 1; e_we = 1; e_len = 2; e_idx = in_parcel[7:4];
          e_data = s8 + in_addr + 64'd2; e_tag = "R2";
        end else if (in_parcel[15:11] == 5'd21 && in_parcel[10:8] >= 3'b101 && in_parcel[3:0] == 0) begin
          total = (in_parcel[10:8] == 3'b101) ? 1 : (in_parcel[10:8] == 3'b110) ? 2 : 4;
          need = total; got = 0; m_imm = 0; m_base = in_addr; m_idx = in_parcel[7:4];
        end else begin
          e_done = 1; e_len = 2;
          e_tag = (in_parcel[15:11] == 5'd21) ? "R5" : "R3";
        end
      end else begin
        m_imm = m_imm | (64'(in_parcel) << (16 * got));
        got++;
        if (got == total) begin
          logic [63:0] ext;
          int bits;
          bits = 16 * total;
          ext = (bits == 64) ? m_imm :
                ((m_imm[bits-1]) ? (m_imm | (~64'h0 << bits)) : m_imm);
          e_done = 1; e_we = 1; e_len = 4'(2 + 2 * total); e_idx = m_idx;
          e_data = ext + m_base + 64'(e_len); e_tag = "R7";
          need = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_busy;
    e_busy = (need != 0);
    if (!rst_n) begin
      chk("R1 reset done", 64'(done_a), 64'(1'b0));
      chk("R1 reset busy", 64'(busy_a), 64'(1'b0));
      chk("R1 reset wr_en", 64'(we_a), 64'(1'b0));
      chk("R1 reset in_rdy", 64'(rdy_a), 64'(1'b1));
    end else begin
      chk("R10 done", 64'(done_a), 64'(e_done));
      chk("R10 wr_en", 64'(we_a), 64'(e_we));
      chk("R9 busy", 64'(busy_a), 64'(e_busy));
      chk("R9 busy w16", 64'(busy_b), 64'(e_busy));
      chk("R10 done w16", 64'(done_b), 64'(e_done));
      chk("R1 in_rdy", 64'(rdy_a & rdy_b), 64'(1'b1));
      if (e_done) begin
        chk({e_tag, " R4 len"}, 64'(len_a), 64'(e_len));
        chk({e_tag, " len w16"}, 64'(len_b), 64'(e_len));
        chk({e_tag, " wr_en w16"}, 64'(we_b), 64'(e_we));
        if (e_we) begin
          chk({e_tag, " R4 idx"}, 64'(idx_a), 64'(e_idx));
          chk({e_tag, " R6 data"}, data_a, e_data);
          chk({e_tag, " R8 data w16"}, 64'(data_b), 64'(e_data[15:0]));
        end
      end
    end
  end

  task automatic put(input logic [15:0] p, input logic [63:0] a, input int gap);
    for (int i = 0; i < gap; i++) begin
      in_vld = 0; in_parcel = 16'hDEAD;
      @(posedge clk); #2;
    end
    in_vld = 1; in_parcel = p; in_addr = a;
    @(posedge clk); #2;
    in_vld = 0;
  endtask

  task automatic long_form(input logic [2:0] sub, input logic [3:0] r, input logic [63:0] a,
                           input logic [63:0] imm, input int gap);
    int n;
    n = (sub == 3'b101) ? 1 : (sub == 3'b110) ? 2 : 4;
    put({5'd21, sub, r, 4'h0}, a, gap);
    for (int k = 0; k < n; k++) put(imm[16*k +: 16], a + 64'(2 + 2 * k), gap);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
      begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R2 short forms, positive and negative
        put(16'hE53A, 64'h1000, 0);
        put(16'hEF8E, 64'h0000_0000_0000_0004, 0);
        // R3 plain parcels
        put(16'hBF00, 64'h2000, 0);
        put(16'h0100, 64'h2002, 1);
        // R5 near misses
        put(16'hAC50, 64'h2004, 0);
        put(16'hAD51, 64'h2006, 0);
        // R6 R7 long forms, back to back and with gaps
        long_form(3'b101, 4'h3, 64'h3000, 64'h7FFF, 0);
        long_form(3'b101, 4'h4, 64'h0002, 64'hFFF0, 2);
        long_form(3'b110, 4'h5, 64'h4000, 64'h8000_1234, 0);
        long_form(3'b110, 4'h6, 64'h4100, 64'h1234_5678, 3);
        long_form(3'b111, 4'h7, 64'h5000, 64'h8123_4567_89AB_CDEF, 0);
        long_form(3'b111, 4'h8, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0100, 1);
        // R8 wrap at 16 bits
        long_form(3'b110, 4'h9, 64'h0000_0000_0000_FFFA, 64'h0001_0010, 0);
        for (int t = 0; t < 400; t++) begin
          int sel;
          logic [63:0] a, im;
          sel = $urandom_range(0, 5);
          a = {$urandom, $urandom} & ~64'h1;
          im = {$urandom, $urandom};
          case (sel)
            0: put({4'hE, 12'($urandom)}, a, $urandom_range(0, 1));
            1: put(16'($urandom), a, $urandom_range(0, 1));
            2: long_form(3'b101, 4'($urandom), a, im, $urandom_range(0, 2));
            3: long_form(3'b110, 4'($urandom), a, im, $urandom_range(0, 2));
            default: long_form(3'b111, 4'($urandom), a, im, $urandom_range(0, 2));
          endcase
        end
        repeat (4) @(posedge clk);
      end
    join_any
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule